// File: doc/BRIEF.md
# Fault-Driven Trip Sequencer

This block watches four active-high fault flags (for example over-current, over-voltage, switch failure and a speed-limit flag) and turns them into a latched 4-bit trip code for downstream power-stage shutdown logic. The fault pins are synchronized and sampled every cycle while the sequencer is idle and enabled. The first nonzero sample is captured, and that pattern indexes a 16-entry table of trip codes that software can program. A zero entry means "no action", and the sequencer returns to sampling.

When the looked-up code is nonzero and a freewheeling interval is programmed, the trip outputs first carry the all-switches-off pattern 0xA for that number of cycles. The trip code is then driven and copied into a status register. The trip stays latched until software writes a clear request. Consuming that request zeroes the outputs, the status and the request itself, and reloads the freewheeling interval.

Software reaches every setting through a plain single-cycle register port. Writes are always accepted in the cycle they are presented and reads are combinational, so the port never applies back-pressure and has no valid/ready handshake. The fault inputs and the trip outputs are plain level signals.

Top module: `trip_sequencer`

## Requirements
- R1: After reset the trip outputs are 0, the status register (address 0x10) reads 0 and the clear register (address 0x11) reads 0.
- R2: The version register at address 0x12 always reads 2, and writes to it have no effect.
- R3: Fault pins pass through two synchronizing flops. With the freewheeling interval at 0, a fault pattern applied before rising edge k appears as its trip code on the trip outputs after edge k+4, and not earlier.
- R4: Table entries sit at addresses 0x00 to 0x0F, indexed by the fault pattern (bit 0 is fault pin 0), with the code in data bits 3:0. A zero entry leaves the trip outputs and the status at 0, and the sequencer keeps sampling.
- R5: With a freewheeling interval N > 0 (address 0x13), the trip outputs carry 0xA for exactly N cycles, starting at the cycle the trip code would otherwise have appeared, and the code follows immediately.
- R6: Once tripped, the status register reads the same code that is on the trip outputs.
- R7: While tripped, changes on the fault pins do not alter the trip outputs or the status.
- R8: Writing a nonzero value to the clear register while tripped sets the trip outputs and status to 0 on the next cycle, reads the clear register back as 0, and reloads the freewheeling interval for the next trip.
- R9: A clear write made while not tripped is discarded: the clear register reads 0 and a later trip stays latched.
- R10: While the enable pin is low, faults are not captured and the trip outputs stay 0.
- R11: The freewheeling interval register reads back the value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seq_en | input | 1 | Enables fault capture while idle |
| fault_in | input | 4 | Asynchronous active-high fault flags |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational register read data |
| trip_out | output | 4 | Trip code toward the power-stage shutdown inputs |

## Verification
A corrupted sequencer state shows up on `trip_out` within one cycle: the code is missing at edge k+4, the 0xA phase is stretched or shortened, or a latched code drops when the faults change. A captured pattern that is lost or replaced after capture shows as the wrong code on the outputs and in status. A stale freewheeling count only becomes visible on the next trip after a clear, which is why the bench trips twice in a row with the interval set. A clear flag held outside a trip appears at address 0x11 at once, and on the next trip as an immediate unlatch.

// File: rtl/trip_seq_pkg.sv
package trip_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_DECIDE,
    ST_FREEWHEEL,
    ST_TRIPPED
  } seq_state_e;

  // offsets inside the upper half of the register space
  localparam int unsigned SEL_STATUS  = 0;
  localparam int unsigned SEL_CLEAR   = 1;
  localparam int unsigned SEL_VERSION = 2;
  localparam int unsigned SEL_FWTIME  = 3;
endpackage

// File: rtl/fault_sync.sv
module fault_sync #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stab_q;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        meta_q[b] <= 1'b0;
        stab_q[b] <= 1'b0;
      end else begin
        meta_q[b] <= async_in[b];
        stab_q[b] <= meta_q[b];
      end
    end
  end

  assign sync_out = stab_q;

  // R3
  sync_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stab_q == $past(meta_q));
endmodule

// File: rtl/trip_regfile.sv
module trip_regfile
  import trip_seq_pkg::*;
#(
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned CODE_W  = 4,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned VERSION = 2,
  localparam int unsigned ADDR_W = IDX_W + 1,
  localparam int unsigned DEPTH  = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [IDX_W-1:0]  lut_idx,
  output logic [CODE_W-1:0] lut_code,
  output logic [CNT_W-1:0]  fw_time,
  input  logic [CODE_W-1:0] status,
  input  logic              tripped,
  input  logic              clr_consume,
  output logic              clr_pending
);
  logic [CODE_W-1:0] lut_q [DEPTH];
  logic [CNT_W-1:0]  fw_q;
  logic              clr_q;
  logic              sel_table;
  logic [IDX_W-1:0]  sel_low;

  assign sel_table = ~addr[ADDR_W-1];
  assign sel_low   = addr[IDX_W-1:0];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) lut_q[e] <= '0;
      else if (wr_en && sel_table && sel_low == IDX_W'(e))
        lut_q[e] <= wdata[CODE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fw_q  <= '0;
      clr_q <= 1'b0;
    end else begin
      if (wr_en && !sel_table && sel_low == IDX_W'(SEL_FWTIME))
        fw_q <= wdata[CNT_W-1:0];
      if (clr_consume)
        clr_q <= 1'b0;
      else if (wr_en && !sel_table && sel_low == IDX_W'(SEL_CLEAR) && tripped)
        clr_q <= |wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel_table) rdata = DATA_W'(lut_q[sel_low]);
    else begin
      case (sel_low)
        IDX_W'(SEL_STATUS):  rdata = DATA_W'(status);
        IDX_W'(SEL_CLEAR):   rdata = DATA_W'(clr_q);
        IDX_W'(SEL_VERSION): rdata = DATA_W'(VERSION);
        IDX_W'(SEL_FWTIME):  rdata = DATA_W'(fw_q);
        default:             rdata = '0;
      endcase
    end
  end

  assign lut_code    = lut_q[lut_idx];
  assign fw_time     = fw_q;
  assign clr_pending = clr_q;

  // R9
  clr_only_tripped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tripped |-> !clr_q);

  // R8
  clr_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_consume |=> !clr_q);
endmodule

// File: rtl/trip_fsm.sv
module trip_fsm
  import trip_seq_pkg::*;
#(
  parameter int unsigned   IDX_W   = 4,
  parameter int unsigned   CODE_W  = 4,
  parameter int unsigned   CNT_W   = 32,
  parameter logic [CODE_W-1:0] FW_CODE = 'hA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [IDX_W-1:0]  fault_s,
  input  logic [CNT_W-1:0]  fw_time,
  input  logic [CODE_W-1:0] lut_code,
  input  logic              clr_pending,
  output logic [IDX_W-1:0]  lut_idx,
  output logic [CODE_W-1:0] trip_out,
  output logic [CODE_W-1:0] status,
  output logic              tripped,
  output logic              clr_consume
);
  seq_state_e        state_q;
  logic [IDX_W-1:0]  pattern_q;
  logic [CODE_W-1:0] code_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CODE_W-1:0] trip_q;
  logic [CODE_W-1:0] status_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      pattern_q <= '0;
      code_q    <= '0;
      cnt_q     <= '0;
      trip_q    <= '0;
      status_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          cnt_q <= fw_time;
          if (enable && |fault_s) begin
            pattern_q <= fault_s;
            state_q   <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          code_q  <= lut_code;
          state_q <= ST_DECIDE;
        end
        ST_DECIDE: begin
          if (code_q == '0) state_q <= ST_IDLE;
          else if (cnt_q == '0) begin
            trip_q   <= code_q;
            status_q <= code_q;
            state_q  <= ST_TRIPPED;
          end else begin
            trip_q  <= FW_CODE;
            state_q <= ST_FREEWHEEL;
          end
        end
        ST_FREEWHEEL: begin
          cnt_q <= cnt_q - CNT_W'(1);
          if (cnt_q == CNT_W'(1)) begin
            trip_q   <= code_q;
            status_q <= code_q;
            state_q  <= ST_TRIPPED;
          end
        end
        ST_TRIPPED: begin
          if (clr_pending) begin
            trip_q   <= '0;
            status_q <= '0;
            state_q  <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign lut_idx     = pattern_q;
  assign trip_out    = trip_q;
  assign status      = status_q;
  assign tripped     = (state_q == ST_TRIPPED);
  assign clr_consume = (state_q == ST_TRIPPED) && clr_pending;

  // R5
  fw_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_FREEWHEEL |-> trip_q == FW_CODE);

  // R5
  fw_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_FREEWHEEL |=> cnt_q == $past(cnt_q) - CNT_W'(1));

  // R7
  pattern_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) != ST_IDLE && state_q != ST_IDLE) |-> $stable(pattern_q));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_IDLE |-> (trip_q == '0 && status_q == '0));

  // R6
  status_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_TRIPPED |-> (status_q == trip_q && status_q != '0));
endmodule

// File: rtl/trip_sequencer.sv
module trip_sequencer
  import trip_seq_pkg::*;
#(
  parameter int unsigned FAULT_W = 4,
  parameter int unsigned CODE_W  = 4,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned VERSION = 2,
  parameter logic [CODE_W-1:0] FW_CODE = 'hA,
  localparam int unsigned ADDR_W = FAULT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seq_en,
  input  logic [FAULT_W-1:0] fault_in,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [CODE_W-1:0] trip_out
);
  logic [FAULT_W-1:0] fault_s;
  logic [FAULT_W-1:0] lut_idx;
  logic [CODE_W-1:0]  lut_code;
  logic [CNT_W-1:0]   fw_time;
  logic [CODE_W-1:0]  status;
  logic               tripped;
  logic               clr_consume;
  logic               clr_pending;

  fault_sync #(.WIDTH(FAULT_W)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (fault_in),
    .sync_out (fault_s)
  );

  trip_regfile #(
    .IDX_W   (FAULT_W),
    .CODE_W  (CODE_W),
    .CNT_W   (CNT_W),
    .DATA_W  (DATA_W),
    .VERSION (VERSION)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (reg_wr),
    .addr        (reg_addr),
    .wdata       (reg_wdata),
    .rdata       (reg_rdata),
    .lut_idx     (lut_idx),
    .lut_code    (lut_code),
    .fw_time     (fw_time),
    .status      (status),
    .tripped     (tripped),
    .clr_consume (clr_consume),
    .clr_pending (clr_pending)
  );

  trip_fsm #(
    .IDX_W   (FAULT_W),
    .CODE_W  (CODE_W),
    .CNT_W   (CNT_W),
    .FW_CODE (FW_CODE)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (seq_en),
    .fault_s     (fault_s),
    .fw_time     (fw_time),
    .lut_code    (lut_code),
    .clr_pending (clr_pending),
    .lut_idx     (lut_idx),
    .trip_out    (trip_out),
    .status      (status),
    .tripped     (tripped),
    .clr_consume (clr_consume)
  );
endmodule

// File: tb/test_trip_sequencer.sv
module test_trip_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seq_en = 1'b0;
  logic [3:0]  fault_in = '0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  trip_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic [3:0] exp_lut [16];

  always #2 clk = ~clk;

  trip_sequencer i_trip_sequencer (
    .clk(clk), .rst_n(rst_n), .seq_en(seq_en), .fault_in(fault_in),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .trip_out(trip_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic clear_trip();
    logic [31:0] rd;
    fault_in = '0;
    reg_write(5'h11, 32'h1);
    @(negedge clk);
    check("R8 trip_out after clear", trip_out, 0);
    reg_read(5'h10, rd);
    check("R8 status after clear", rd, 0);
    reg_read(5'h11, rd);
    check("R8 clear reg consumed", rd, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] rd;
    @(negedge clk);
    check("R1 trip_out reset", trip_out, 0);
    reg_read(5'h10, rd); check("R1 status reset", rd, 0);
    reg_read(5'h11, rd); check("R1 clear reset", rd, 0);
  endtask

  task automatic t_version();
    logic [31:0] rd;
    reg_read(5'h12, rd); check("R2 version", rd, 2);
    reg_write(5'h12, 32'h55);
    reg_read(5'h12, rd); check("R2 version after write", rd, 2);
  endtask

  task automatic program_table();
    logic [31:0] rd;
    for (int i = 0; i < 16; i++) begin
      exp_lut[i] = 4'(i) ^ 4'h5;
      reg_write(5'(i), {28'hABCDEF0, exp_lut[i]});
    end
    reg_read(5'h09, rd); check("R4 table readback", rd, 32'(exp_lut[9]));
  endtask

  task automatic t_direct_trip();
    logic [31:0] rd;
    @(negedge clk);
    fault_in = 4'b0010;
    repeat (4) @(negedge clk);
    check("R3 no trip before edge k+4", trip_out, 0);
    @(negedge clk);
    check("R3 trip code at edge k+4", trip_out, exp_lut[2]);
    reg_read(5'h10, rd); check("R6 status equals code", rd, 32'(exp_lut[2]));
    fault_in = 4'b1000;
    repeat (8) @(negedge clk);
    check("R7 trip held on fault change", trip_out, exp_lut[2]);
    reg_read(5'h10, rd); check("R7 status held", rd, 32'(exp_lut[2]));
    clear_trip();
  endtask

  task automatic t_zero_entry();
    logic [31:0] rd;
    @(negedge clk);
    fault_in = 4'b0101;
    repeat (12) @(negedge clk);
    check("R4 zero entry no trip", trip_out, 0);
    reg_read(5'h10, rd); check("R4 zero entry status", rd, 0);
    fault_in = 4'b0100;
    repeat (6) @(negedge clk);
    check("R4 sampling resumes", trip_out, exp_lut[4]);
    clear_trip();
  endtask

  task automatic fw_run(input string tag);
    fault_in = 4'b0011;
    repeat (4) @(negedge clk);
    check({tag, " before off phase"}, trip_out, 0);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check({tag, " off pattern"}, trip_out, 4'hA);
    end
    @(negedge clk);
    check({tag, " code after interval"}, trip_out, exp_lut[3]);
  endtask

  task automatic t_freewheel();
    logic [31:0] rd;
    reg_write(5'h13, 32'd3);
    reg_read(5'h13, rd); check("R11 interval readback", rd, 3);
    fw_run("R5");
    clear_trip();
    @(negedge clk);
    fw_run("R8 reload");
    clear_trip();
    reg_write(5'h13, 32'd0);
  endtask

  task automatic t_clear_ignored();
    logic [31:0] rd;
    reg_write(5'h11, 32'h1);
    reg_read(5'h11, rd); check("R9 idle clear discarded", rd, 0);
    fault_in = 4'b0001;
    repeat (16) @(negedge clk);
    check("R9 trip stays latched", trip_out, exp_lut[1]);
    clear_trip();
  endtask

  task automatic t_disabled();
    seq_en = 1'b0;
    fault_in = 4'b0001;
    repeat (12) @(negedge clk);
    check("R10 disabled no trip", trip_out, 0);
    seq_en = 1'b1;
    repeat (6) @(negedge clk);
    check("R10 enable captures", trip_out, exp_lut[1]);
    clear_trip();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_version();
    program_table();
    seq_en = 1'b1;
    t_direct_trip();
    t_zero_entry();
    t_freewheel();
    t_clear_ignored();
    t_disabled();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule